// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block places a 64×64 bitmap cursor over a scan-out pixel stream. Software sets it up through a small indexed write port. For each visible line the block loads one line of the cursor bitmap from video memory into a local line buffer, and it does this during the horizontal blanking of the line before. While the line is being scanned, the block compares the raster X coordinate with the cursor position. Where the cursor covers a pixel, the block replaces the incoming pixel according to that pixel's 2-bit cursor code.

Two offset registers allow the cursor to slide partly off the left or top edge of the screen:

- The horizontal offset names the first drawn bitmap column, counted from the bitmap's right edge.
- The vertical offset names the first drawn bitmap row, counted from the top.

Other registers set where the bitmap starts in memory and how far apart its lines are. The start address is in bytes or in 32-bit words. The line pitch is 16 or 32 bytes. Cursor data can be taken from every byte or only from even bytes.

Top module: `cursor_overlay`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `pix_out` is 0 and `mem_req` is 0. All configuration registers reset to 0, so the cursor is disabled.
- R2: Writing `reg_wdata` to register `reg_idx` when `reg_we` is high takes effect at the next clock edge. The register indices are:
  - 0 and 1: cursor X, low byte then high byte.
  - 2 and 3: cursor Y, low byte then high byte.
  - 4: horizontal skip.
  - 5: vertical skip.
  - 6, 7 and 8: map base address, bytes 0 to 2.
  - 9: pitch code.
  - 10: load mode.
  - 11: control. Bit 7 enables the cursor and bit 0 selects word addressing.
- R3: While control bit 7 is 0, `pix_out` equals `pix_in` delayed by one clock and no fetch starts.
- R4: The cursor code of a covered pixel maps to the output, one clock after the input pixel, as follows:
  - Code 0 passes `pix_in`.
  - Code 1 outputs its bitwise inverse.
  - Code 2 outputs parameter `CLR0`.
  - Code 3 outputs parameter `CLR1`.
- R5: Let d = `raster_x` − X, and number bitmap columns 0 at the right edge up to 63 at the left edge. For 0 ≤ d < 64, the pixel shows column (horizontal skip − d) when that value lies between 0 and 63. Otherwise the pixel passes unchanged.
- R6: Screen line y shows bitmap row (y − Y + vertical skip) when 0 ≤ y − Y < 64 and that row is below 64. Otherwise the whole line passes unchanged.
- R7: A rising edge of `hblank` on line y starts a fetch for line y+1 when the cursor is enabled and line y+1 is covered. The fetch is exactly 16 single-byte reads. At most 16 reads are accepted per blanking interval.
- R8: The pitch code c sets the distance between bitmap lines in memory to 8·c bytes, so 2 gives 16 bytes and 4 gives 32 bytes.
- R9: Load mode 2 reads every second byte (address step 2). Any other value, including 1, reads consecutive bytes.
- R10: With control bit 0 set, the base address counts 32-bit words and is multiplied by 4; otherwise it counts bytes. Address arithmetic wraps at 24 bits.
- R11: `mem_req` stays high with `mem_addr` unchanged until `mem_ready` is seen. Read data returns in request order on `mem_rvalid`. The k-th returned byte holds columns 4k to 4k+3 counted from the left, with the left-most of the four in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register index |
| reg_wdata | input | 8 | Register write data |
| mem_req | output | 1 | Memory read request |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_addr | output | 24 | Byte address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data |
| raster_x | input | 16 | Current pixel column |
| raster_y | input | 16 | Current scan line |
| hblank | input | 1 | Horizontal blanking active |
| pix_in | input | PIX_W | Underlying pixel |
| pix_out | output | PIX_W | Pixel with cursor applied, one clock later |

## Verification
The assertions check four rules on every cycle:
- The request handshake holds its address while stalled.
- No blanking interval sees more than 16 accepted reads.
- The output is always one of the four permitted choices (the delayed input, its inverse, `CLR0` or `CLR1`).
- A disabled cursor is a pure one-clock delay.

Only the bench's whole-frame scenarios can show the rest. That covers which bitmap column and row land on which screen pixel under the skip offsets, and how the pitch, load mode and word addressing shape the fetched data. It also covers rows beyond the bitmap clipping to pass-through, and base addresses wrapping at 24 bits.

// File: rtl/cur_pkg.sv
package cur_pkg;

    localparam int ADDR_W     = 24;
    localparam int CUR_DIM    = 64;
    localparam int CODE_W     = 2;
    localparam int LINE_BITS  = CUR_DIM * CODE_W;
    localparam int LINE_BYTES = LINE_BITS / 8;
    localparam int CNT_W      = $clog2(LINE_BYTES) + 1;
    localparam int COL_W      = $clog2(CUR_DIM);

    typedef enum logic [CODE_W-1:0] {
        PX_CLEAR  = 2'd0,
        PX_INVERT = 2'd1,
        PX_COL0   = 2'd2,
        PX_COL1   = 2'd3
    } px_code_e;

    typedef struct packed {
        logic [15:0]       xpos;
        logic [15:0]       ypos;
        logic [7:0]        skip_x;
        logic [7:0]        skip_y;
        logic [ADDR_W-1:0] base;
        logic [7:0]        pitch;
        logic [7:0]        lmode;
        logic              enable;
        logic              word_mode;
    } cur_cfg_t;

    function automatic logic [ADDR_W-1:0] byte_base(input logic [ADDR_W-1:0] b,
                                                    input logic word_mode);
        return word_mode ? {b[ADDR_W-3:0], 2'b00} : b;
    endfunction

    function automatic logic [ADDR_W-1:0] fetch_step(input logic [7:0] lmode);
        return (lmode == 8'd2) ? ADDR_W'(2) : ADDR_W'(1);
    endfunction

endpackage

// File: rtl/cur_regs.sv
module cur_regs
    import cur_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [3:0] idx,
    input  logic [7:0] wdata,
    output cur_cfg_t   cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            case (idx)
                4'd0:  cfg.xpos[7:0]    <= wdata;
                4'd1:  cfg.xpos[15:8]   <= wdata;
                4'd2:  cfg.ypos[7:0]    <= wdata;
                4'd3:  cfg.ypos[15:8]   <= wdata;
                4'd4:  cfg.skip_x       <= wdata;
                4'd5:  cfg.skip_y       <= wdata;
                4'd6:  cfg.base[7:0]    <= wdata;
                4'd7:  cfg.base[15:8]   <= wdata;
                4'd8:  cfg.base[23:16]  <= wdata;
                4'd9:  cfg.pitch        <= wdata;
                4'd10: cfg.lmode        <= wdata;
                4'd11: begin
                    cfg.enable    <= wdata[7];
                    cfg.word_mode <= wdata[0];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cur_fetch.sv
module cur_fetch
    import cur_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  cur_cfg_t             cfg,
    input  logic [15:0]          raster_y,
    input  logic                 hblank,
    output logic                 mem_req,
    input  logic                 mem_ready,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic                 mem_rvalid,
    input  logic [7:0]           mem_rdata,
    output logic [LINE_BITS-1:0] line_buf,
    output logic                 line_ok
);

    logic              hb_q, hb_rise, busy;
    logic [CNT_W-1:0]  req_cnt, rsp_cnt;
    logic [ADDR_W-1:0] cur_addr, step, row_off;
    logic [16:0]       next_y, dy;
    logic [8:0]        row_sum;
    logic              y_hit;

    assign hb_rise = hblank & ~hb_q;
    assign next_y  = {1'b0, raster_y} + 17'd1;
    assign dy      = next_y - {1'b0, cfg.ypos};
    assign row_sum = {3'b000, dy[COL_W-1:0]} + {1'b0, cfg.skip_y};
    assign y_hit   = (next_y >= {1'b0, cfg.ypos}) && (dy < 17'(CUR_DIM))
                     && (row_sum < 9'(CUR_DIM));
    assign row_off = ADDR_W'(row_sum[COL_W-1:0]) * ADDR_W'({cfg.pitch, 3'b000});

    assign mem_req  = busy && (req_cnt < CNT_W'(LINE_BYTES));
    assign mem_addr = cur_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            hb_q     <= 1'b0;
            busy     <= 1'b0;
            req_cnt  <= '0;
            rsp_cnt  <= '0;
            cur_addr <= '0;
            step     <= '0;
            line_buf <= '0;
            line_ok  <= 1'b0;
        end else begin
            hb_q <= hblank;
            if (hb_rise) begin
                line_ok  <= 1'b0;
                busy     <= cfg.enable && y_hit;
                req_cnt  <= '0;
                rsp_cnt  <= '0;
                cur_addr <= byte_base(cfg.base, cfg.word_mode) + row_off;
                step     <= fetch_step(cfg.lmode);
            end else if (busy) begin
                if (mem_req && mem_ready) begin
                    cur_addr <= cur_addr + step;
                    req_cnt  <= req_cnt + 1'b1;
                end
                if (mem_rvalid) begin
                    line_buf[{rsp_cnt[CNT_W-2:0], 3'b000} +: 8] <= mem_rdata;
                    rsp_cnt <= rsp_cnt + 1'b1;
                    if (rsp_cnt == CNT_W'(LINE_BYTES - 1)) begin
                        busy    <= 1'b0;
                        line_ok <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/cur_mix.sv
module cur_mix
    import cur_pkg::*;
#(
    parameter int              PIX_W = 8,
    parameter logic [PIX_W-1:0] CLR0 = '0,
    parameter logic [PIX_W-1:0] CLR1 = '1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  cur_cfg_t             cfg,
    input  logic [15:0]          raster_x,
    input  logic [PIX_W-1:0]     pix_in,
    input  logic [LINE_BITS-1:0] line_buf,
    input  logic                 line_ok,
    output logic [PIX_W-1:0]     pix_out
);

    logic [15:0]      dx;
    logic [7:0]       col_r;
    logic [COL_W-1:0] col_l;
    logic             covered;
    px_code_e         code;
    logic [PIX_W-1:0] mixed;

    assign dx      = raster_x - cfg.xpos;
    assign col_r   = cfg.skip_x - dx[7:0];
    assign col_l   = COL_W'(CUR_DIM - 1) - col_r[COL_W-1:0];
    assign covered = cfg.enable && line_ok && (raster_x >= cfg.xpos)
                     && (dx < 16'(CUR_DIM)) && (dx[7:0] <= cfg.skip_x)
                     && (col_r < 8'(CUR_DIM));
    assign code    = px_code_e'(line_buf[{col_l, 1'b0} +: CODE_W]);

    always_comb begin
        mixed = pix_in;
        if (covered) begin
            case (code)
                PX_INVERT: mixed = ~pix_in;
                PX_COL0:   mixed = CLR0;
                PX_COL1:   mixed = CLR1;
                default:   mixed = pix_in;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pix_out <= '0;
        else     pix_out <= mixed;
    end

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cur_pkg::*;
#(
    parameter int               PIX_W = 8,
    parameter logic [PIX_W-1:0] CLR0  = '0,
    parameter logic [PIX_W-1:0] CLR1  = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [3:0]        reg_idx,
    input  logic [7:0]        reg_wdata,
    output logic              mem_req,
    input  logic              mem_ready,
    output logic [23:0]       mem_addr,
    input  logic              mem_rvalid,
    input  logic [7:0]        mem_rdata,
    input  logic [15:0]       raster_x,
    input  logic [15:0]       raster_y,
    input  logic              hblank,
    input  logic [PIX_W-1:0]  pix_in,
    output logic [PIX_W-1:0]  pix_out
);

    cur_cfg_t             cfg;
    logic [LINE_BITS-1:0] line_buf;
    logic                 line_ok;

    cur_regs u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .idx(reg_idx),
        .wdata(reg_wdata), .cfg(cfg)
    );

    cur_fetch u_fetch (
        .clk(clk), .rst(rst), .cfg(cfg), .raster_y(raster_y), .hblank(hblank),
        .mem_req(mem_req), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .line_buf(line_buf), .line_ok(line_ok)
    );

    cur_mix #(.PIX_W(PIX_W), .CLR0(CLR0), .CLR1(CLR1)) u_mix (
        .clk(clk), .rst(rst), .cfg(cfg), .raster_x(raster_x), .pix_in(pix_in),
        .line_buf(line_buf), .line_ok(line_ok), .pix_out(pix_out)
    );

endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
    parameter int               PIX_W = 8,
    parameter logic [PIX_W-1:0] CLR0  = '0,
    parameter logic [PIX_W-1:0] CLR1  = '1
) (
    input logic              clk,
    input logic              rst,
    input logic              hblank,
    input logic              mem_req,
    input logic              mem_ready,
    input logic [23:0]       mem_addr,
    input logic [PIX_W-1:0]  pix_in,
    input logic [PIX_W-1:0]  pix_out,
    input logic              en
);

    logic       hb_q;
    logic [5:0] acc_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hb_q    <= 1'b0;
            acc_cnt <= '0;
        end else begin
            hb_q <= hblank;
            if (hblank && !hb_q)
                acc_cnt <= '0;
            else if (mem_req && mem_ready && acc_cnt != 6'h3F)
                acc_cnt <= acc_cnt + 1'b1;
        end
    end

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    // R7
    fetch_budget_chk: assert property (@(posedge clk) disable iff (rst)
        acc_cnt <= 6'd16);

    // R3
    off_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(en)) |-> (pix_out == $past(pix_in)));

    // R4
    out_choice_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (pix_out == $past(pix_in) || pix_out == ~$past(pix_in)
                         || pix_out == CLR0 || pix_out == CLR1));

endmodule

bind cursor_overlay cursor_overlay_chk #(.PIX_W(PIX_W), .CLR0(CLR0), .CLR1(CLR1)) u_chk (
    .clk(clk), .rst(rst), .hblank(hblank), .mem_req(mem_req), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .pix_in(pix_in), .pix_out(pix_out), .en(cfg.enable)
);

// File: tb/cursor_overlay_tb.sv
module cursor_overlay_tb;

    localparam int CLK_PERIOD = 10;
    localparam int H_ACT = 120;
    localparam int H_TOT = 160;
    localparam int V_TOT = 72;
    localparam logic [7:0] C0 = 8'h11;
    localparam logic [7:0] C1 = 8'hEE;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_idx = '0;
    logic [7:0]  reg_wdata = '0;
    logic        mem_req, mem_ready = 1'b0;
    logic [23:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] raster_x = 16'hFFF0, raster_y = '0;
    logic        hblank = 1'b1;
    logic [7:0]  pix_in = '0, pix_out;

    cursor_overlay #(.PIX_W(8), .CLR0(C0), .CLR1(C1)) u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .raster_x(raster_x), .raster_y(raster_y), .hblank(hblank),
        .pix_in(pix_in), .pix_out(pix_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct { logic [7:0] exp; string tag; } item_t;
    item_t sb[$];
    int total = 0, bad = 0;
    bit done = 0;
    bit scoring = 0;

    // bench model of the programmed registers
    logic [15:0] m_x = 0, m_y = 0;
    logic [7:0]  m_sx = 0, m_sy = 0, m_pitch = 0, m_lmode = 0, m_ctrl = 0;
    logic [23:0] m_base = 0;
    logic [127:0] m_row = '0;
    bit          m_row_ok = 0;
    bit          last_hb = 1;
    int          line_acc = 0;

    function automatic logic [7:0] md(input logic [23:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h3C;
    endfunction

    function automatic void model_fetch(input int ny);
        int dyv, r;
        logic [23:0] b, st, a;
        m_row_ok = 0;
        dyv = ny - int'(m_y);
        if (!m_ctrl[7] || dyv < 0 || dyv >= 64) return;
        r = dyv + int'(m_sy);
        if (r >= 64) return;
        b  = m_ctrl[0] ? {m_base[21:0], 2'b00} : m_base;
        st = (m_lmode == 8'd2) ? 24'd2 : 24'd1;
        for (int k = 0; k < 16; k++) begin
            a = b + 24'(r) * 24'({m_pitch, 3'b000}) + 24'(k) * st;
            m_row[8*k +: 8] = md(a);
        end
        m_row_ok = 1;
    endfunction

    function automatic logic [7:0] exp_pix(input int x, input logic [7:0] pin);
        int dx, cr, cl;
        logic [1:0] code;
        if (!m_ctrl[7] || !m_row_ok) return pin;
        dx = x - int'(m_x);
        if (dx < 0 || dx >= 64) return pin;
        cr = int'(m_sx) - dx;
        if (cr < 0 || cr > 63) return pin;
        cl = 63 - cr;
        code = m_row[2*cl +: 2];
        case (code)
            2'd1: return ~pin;
            2'd2: return C0;
            2'd3: return C1;
            default: return pin;
        endcase
    endfunction

    // one driven cycle at the falling edge
    task automatic drive(input int x, input int y, input bit hb, input string tag);
        logic [7:0] p;
        @(negedge clk);
        reg_we = 1'b0;
        p = 8'(x) ^ {y[3:0], y[7:4]} ^ 8'h5A;
        raster_x = 16'(x); raster_y = 16'(y); hblank = hb; pix_in = p;
        if (hb && !last_hb) begin
            model_fetch(y + 1);
            line_acc = 0;
        end
        last_hb = hb;
        sb.push_back('{exp_pix(x, p), tag});
    endtask

    task automatic wr(input logic [3:0] i, input logic [7:0] v);
        drive(16'hFFF0, V_TOT - 1, 1'b1, "R2");
        reg_we = 1'b1; reg_idx = i; reg_wdata = v;
        case (i)
            4'd0: m_x[7:0] = v;   4'd1: m_x[15:8] = v;
            4'd2: m_y[7:0] = v;   4'd3: m_y[15:8] = v;
            4'd4: m_sx = v;       4'd5: m_sy = v;
            4'd6: m_base[7:0] = v; 4'd7: m_base[15:8] = v; 4'd8: m_base[23:16] = v;
            4'd9: m_pitch = v;    4'd10: m_lmode = v;
            4'd11: m_ctrl = v;
            default: ;
        endcase
    endtask

    task automatic frame(input logic [15:0] x, input logic [15:0] y, input logic [7:0] sx,
                         input logic [7:0] sy, input logic [23:0] b, input logic [7:0] pc,
                         input logic [7:0] lm, input logic [7:0] ctl, input string tag);
        wr(4'd0, x[7:0]);  wr(4'd1, x[15:8]);
        wr(4'd2, y[7:0]);  wr(4'd3, y[15:8]);
        wr(4'd4, sx);      wr(4'd5, sy);
        wr(4'd6, b[7:0]);  wr(4'd7, b[15:8]); wr(4'd8, b[23:16]);
        wr(4'd9, pc);      wr(4'd10, lm);     wr(4'd11, ctl);
        for (int yy = 0; yy < V_TOT; yy++) begin
            for (int xx = 0; xx < H_TOT; xx++) begin
                drive(xx, yy, xx >= H_ACT, tag);
                if (xx == H_TOT - 1) begin
                    // R7: read count per blanking interval
                    total++;
                    if (line_acc != (m_row_ok ? 16 : 0)) begin
                        bad++;
                        $display("FAIL R7 line %0d reads actual=%0d expected=%0d",
                                 yy, line_acc, m_row_ok ? 16 : 0);
                    end
                end
            end
        end
    endtask

    // memory model: 2-cycle read latency, ready two cycles of three
    logic [23:0] d1a = '0, d2a = '0;
    bit d1v = 0, d2v = 0;
    int cyc = 0;
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            mem_rvalid = d2v;
            mem_rdata  = md(d2a);
            d2v = d1v; d2a = d1a;
            mem_ready = (cyc % 3) != 0;
            d1v = mem_req && mem_ready && !rst;
            d1a = mem_addr;
            if (d1v) line_acc++;
        end
    end

    // scoreboard monitor
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (scoring && sb.size() > 0) begin
                it = sb.pop_front();
                total++;
                if (pix_out !== it.exp) begin
                    bad++;
                    $display("FAIL %s pix_out actual=%h expected=%h (x=%0d y=%0d)",
                             it.tag, pix_out, it.exp, raster_x, raster_y);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        total++;
        if (pix_out !== 8'h00 || mem_req !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset actual=%h/%b expected=00/0", pix_out, mem_req);
        end
        rst = 1'b0;
        @(negedge clk);
        total++;
        if (pix_out !== 8'h00 || mem_req !== 1'b0) begin
            bad++;
            $display("FAIL R1 after reset actual=%h/%b expected=00/0", pix_out, mem_req);
        end
        scoring = 1;
        // R3 disabled cursor
        frame(16'd10, 16'd5, 8'd63, 8'd0, 24'h0, 8'd2, 8'd1, 8'h00, "R3");
        // R4 R5 R6 R11: full cursor, byte stepping, pitch 16
        frame(16'd20, 16'd4, 8'd63, 8'd0, 24'h001230, 8'd2, 8'd1, 8'h80, "R4 R5 R6 R11");
        // R8 R9 R10: pitch 32, even bytes, word addressing
        frame(16'd40, 16'd10, 8'd63, 8'd0, 24'h000400, 8'd4, 8'd2, 8'h81, "R8 R9 R10");
        // R5 R6 R10: clipping at the left/top, base wrapping at 24 bits
        frame(16'd0, 16'd1, 8'd20, 8'd40, 24'hFFFFF0, 8'd2, 8'd1, 8'h80, "R5 R6 R10");
        // R5 R9: skip beyond bitmap width, load mode 3 treated as consecutive
        frame(16'd50, 16'd3, 8'd100, 8'd10, 24'h00ABC0, 8'd2, 8'd3, 8'h80, "R5 R9");
        // R6: cursor running past the last line
        frame(16'd5, 16'd30, 8'd63, 8'd0, 24'h020000, 8'd2, 8'd2, 8'h80, "R6");
        repeat (4) drive(16'hFFF0, V_TOT - 1, 1'b1, "R3");
        repeat (4) @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule